// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Stop-Strobe Option

This block is a software watchdog made of two cascaded 8-bit down-counting stages, a high stage and a low stage, which together count 16 bits. After a chip reset the watchdog does not run. The first write of any value to its control register starts it. Every write after that reloads both stages. Software must keep writing the register, or the high stage underflows and the block raises a one-cycle internal reset request.

A prescaled tick enable (the divide-by-16 clock) drives the low stage. One control bit selects what clocks the high stage: either the low stage's underflow, which gives a long timeout, or the tick directly, which gives a short one. A second control bit decides what a stop-instruction strobe does. It either requests entry into stop mode or forces the reset request. Software can set this bit, but the bit can be written only once after each chip reset. The counter keeps running in wait mode. It halts in stop mode, except while the oscillation-stabilise status is active.

Top module: `wdt_core`

## Requirements
- R1: A chip reset (`rst`, synchronous, active high) loads 0xFF into both stages and clears both control bits. After it, `rd_data` reads 0x3F and both `wdt_reset` and `stop_enter` are low.
- R2: Until the first control write after reset, ticks have no effect. `rd_data` stays 0x3F and `wdt_reset` stays low.
- R3: Every control write loads 0xFF into both stages. A tick in the same cycle as a write is ignored.
- R4: With write-data bit 7 = 1, the high stage counts every tick. `wdt_reset` rises after the 256th tick edge following the write.
- R5: With write-data bit 7 = 0, the high stage counts low-stage underflows. `wdt_reset` rises after the 65536th tick edge following the write.
- R6: Control bit 6 (stop-reset select) takes its value from the first write after reset only. Later writes leave it unchanged. It reads back in `rd_data` bit 6.
- R7: A `stop_strobe` with bit 6 = 0 gives a one-cycle `stop_enter` pulse on the next edge. With bit 6 = 1 it gives a one-cycle `wdt_reset` pulse instead.
- R8: While `stop_mode` is high and `osc_stab` is low, ticks do not change the counter. While `osc_stab` is high, counting continues even in stop mode.
- R9: `rd_data` = {bit 7, bit 6, high stage bits 7..2}.
- R10: Each stage wraps from 0x00 to 0xFF on the tick that underflows it. `wdt_reset` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| tick_en | input | 1 | Prescaled count tick, one cycle wide |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control write data |
| rd_data | output | 8 | Control register read value |
| stop_strobe | input | 1 | Stop instruction executed |
| stop_mode | input | 1 | System is in stop mode |
| osc_stab | input | 1 | Oscillation-stabilise interval active |
| stop_enter | output | 1 | One-cycle request to enter stop mode |
| wdt_reset | output | 1 | One-cycle internal reset request |

## Verification
The counting path is tested with a continuous tick stream under both high-stage sources. The exact edge on which the reset appears (256 or 65536) separates a correct cascade from an off-by-one or a wrong source select. Some ticks are applied before the counter is armed and some while stop mode is active, to show they are ignored. A write placed on the same cycle as a tick, followed by a short count read back through the upper high-stage bits, shows whether that tick leaked into the counter. Write sequences of 0x40 then 0x00, and the reverse, separate a true write-once bit from a plain register bit or a sticky-set bit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int STAGE_W = 8;
    localparam int CTRL_W  = 8;
    localparam int HSRC_BIT = 7;
    localparam int SRST_BIT = 6;
    localparam int VIEW_W   = CTRL_W - 2;

    typedef struct packed {
        logic hsrc_tick;   // 1: high stage counts ticks directly
        logic stop_rst;    // 1: stop strobe forces reset
    } wdt_ctrl_t;

    function automatic logic [CTRL_W-1:0] wdt_read(input wdt_ctrl_t c,
                                                   input logic [STAGE_W-1:0] high);
        return {c.hsrc_tick, c.stop_rst, high[STAGE_W-1 -: VIEW_W]};
    endfunction
endpackage

// File: rtl/wdt_stage.sv
module wdt_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         en,
    output logic [W-1:0] q,
    output logic         uf
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    assign uf = en && (q == '0);

    always_ff @(posedge clk) begin
        if (rst || load) q <= ALL_ONES;
        else if (en)     q <= q - 1'b1;
    end

    // R10: an underflow wraps the stage to all ones
    p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (uf && !load) |=> (q == ALL_ONES));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output wdt_ctrl_t         ctrl,
    output logic              armed
);
    logic locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            armed  <= 1'b0;
            locked <= 1'b0;
        end else if (wr_en) begin
            ctrl.hsrc_tick <= wr_data[HSRC_BIT];
            armed          <= 1'b1;
            if (!locked) begin
                ctrl.stop_rst <= wr_data[SRST_BIT];
                locked        <= 1'b1;
            end
        end
    end

    // R6: once set, the stop-reset select cannot be cleared by software
    p_setonly_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl.stop_rst |=> ctrl.stop_rst);
    // R6: after the first write, further writes leave the bit alone
    p_once_r6: assert property (@(posedge clk) disable iff (rst)
        (armed && wr_en) |=> $stable(ctrl.stop_rst));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              stop_strobe,
    input  logic              stop_mode,
    input  logic              osc_stab,
    output logic              stop_enter,
    output logic              wdt_reset
);
    localparam int NSTAGE = 2;

    wdt_ctrl_t          ctrl;
    logic               armed;
    logic               cnt_en;
    logic [NSTAGE-1:0]  st_en;
    logic [NSTAGE-1:0]  st_uf;
    logic [STAGE_W-1:0] st_q [NSTAGE];

    wdt_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .ctrl   (ctrl),
        .armed  (armed)
    );

    // a write in the same cycle wins over the tick
    assign cnt_en = armed && tick_en && !wr_en && (!stop_mode || osc_stab);

    // stage 0 = low, stage 1 = high
    assign st_en[0] = cnt_en;
    assign st_en[1] = ctrl.hsrc_tick ? cnt_en : st_uf[0];

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        wdt_stage #(.W(STAGE_W)) u_stage (
            .clk (clk),
            .rst (rst),
            .load(wr_en),
            .en  (st_en[g]),
            .q   (st_q[g]),
            .uf  (st_uf[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wdt_reset  <= 1'b0;
            stop_enter <= 1'b0;
        end else begin
            wdt_reset  <= st_uf[NSTAGE-1] || (stop_strobe && ctrl.stop_rst);
            stop_enter <= stop_strobe && !ctrl.stop_rst;
        end
    end

    assign rd_data = wdt_read(ctrl, st_q[NSTAGE-1]);

    // R3: a write leaves both stages at all ones
    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (st_q[0] == 8'hFF && st_q[1] == 8'hFF));
    // R2: the counter holds until armed
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !armed |=> (st_q[0] == 8'hFF && st_q[1] == 8'hFF));
    // R8: stop mode without stabilise halts the low stage
    p_halt_r8: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && !osc_stab && !wr_en) |=> $stable(st_q[0]));
    // R7: the two stop outcomes never coincide
    p_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(stop_enter && wdt_reset && !$past(st_uf[NSTAGE-1])));
endmodule

// File: tb/wdt_core_bench.sv
`timescale 1ns/1ps
module wdt_core_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       stop_strobe = 1'b0;
    logic       stop_mode = 1'b0;
    logic       osc_stab = 1'b0;
    logic       stop_enter;
    logic       wdt_reset;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    wdt_core u_wdt_core (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .stop_strobe(stop_strobe), .stop_mode(stop_mode),
        .osc_stab(osc_stab), .stop_enter(stop_enter), .wdt_reset(wdt_reset)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tick_en = 0; wr_en = 0; stop_strobe = 0; stop_mode = 0; osc_stab = 0;
        step();
        rst = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) step();
        tick_en = 1'b0;
    endtask

    task automatic first_reset_edge(input int limit, output int at);
        at = -1;
        tick_en = 1'b1;
        for (int i = 1; i <= limit; i++) begin
            step();
            if (wdt_reset && at < 0) begin
                at = i;
                break;
            end
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 rd", rd_data, 8'h3F);
        chk("R1 wdt_reset", wdt_reset, 0);
        chk("R1 stop_enter", stop_enter, 0);
    endtask

    task automatic t_idle();
        int hits = 0;
        do_reset();
        tick_en = 1'b1;
        for (int i = 0; i < 300; i++) begin
            step();
            if (wdt_reset) hits++;
        end
        tick_en = 1'b0;
        chk("R2 rd unchanged", rd_data, 8'h3F);
        chk("R2 no reset", hits, 0);
    endtask

    task automatic t_short();
        int at;
        do_reset();
        do_write(8'h80);
        ticks(4);
        chk("R9 rd after 4 ticks", rd_data, 8'hBE);
        do_write(8'h80);
        first_reset_edge(400, at);
        chk("R4 reset edge", at, 256);
        step();
        tick_en = 1'b0;
        chk("R10 single pulse", wdt_reset, 0);
        chk("R10 high wrapped", rd_data, 8'hBF);
    endtask

    task automatic t_long();
        int at;
        do_reset();
        do_write(8'h00);
        ticks(256);
        chk("R10 low wrap steps high", rd_data, 8'h3F);
        ticks(768);
        chk("R5 high after 1024 ticks", rd_data, 8'h3E);
        do_write(8'h00);
        first_reset_edge(70000, at);
        tick_en = 1'b0;
        chk("R5 reset edge", at, 65536);
    endtask

    task automatic t_reload();
        do_reset();
        do_write(8'h80);
        ticks(8);
        chk("R3 counted", rd_data, 8'hBD);
        tick_en = 1'b1;
        do_write(8'h80);
        chk("R3 reloaded", rd_data, 8'hBF);
        ticks(3);
        chk("R3 same-cycle tick ignored", rd_data, 8'hBF);
    endtask

    task automatic t_stop_halt();
        do_reset();
        do_write(8'h80);
        stop_mode = 1'b1;
        ticks(8);
        chk("R8 halted", rd_data, 8'hBF);
        osc_stab = 1'b1;
        ticks(8);
        chk("R8 stabilise counts", rd_data, 8'hBD);
        stop_mode = 1'b0; osc_stab = 1'b0;
    endtask

    task automatic t_once();
        do_reset();
        do_write(8'h40);
        chk("R6 set", rd_data, 8'h7F);
        do_write(8'h80);
        chk("R6 not cleared", rd_data, 8'hFF);
        do_reset();
        do_write(8'h00);
        do_write(8'h40);
        chk("R6 write once", rd_data, 8'h3F);
    endtask

    task automatic t_strobe();
        do_reset();
        do_write(8'h00);
        stop_strobe = 1'b1;
        step();
        stop_strobe = 1'b0;
        chk("R7 stop_enter", stop_enter, 1);
        chk("R7 no reset", wdt_reset, 0);
        step();
        chk("R7 stop_enter one cycle", stop_enter, 0);
        do_reset();
        do_write(8'h40);
        stop_strobe = 1'b1;
        step();
        stop_strobe = 1'b0;
        chk("R7 reset on strobe", wdt_reset, 1);
        chk("R7 no stop_enter", stop_enter, 0);
        step();
        chk("R10 reset one cycle", wdt_reset, 0);
    endtask

    task automatic t_midreset();
        do_reset();
        do_write(8'hC0);
        ticks(20);
        do_reset();
        chk("R1 reset clears", rd_data, 8'h3F);
    endtask

    initial begin
        t_reset_state();
        t_idle();
        t_short();
        t_long();
        t_reload();
        t_stop_halt();
        t_once();
        t_strobe();
        t_midreset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule